// File: doc/BRIEF.md
# Shared Bus Ownership Arbiter

This block decides which master owns a shared system bus: the CPU, an on-chip DMA engine, an on-chip DRAM refresh engine, or an off-chip master that asks for the bus over a request/acknowledge pin pair (`hldrq` in, `hldak` out). Exactly one owner is active at a time. The CPU is the default owner and keeps the bus whenever nobody else asks for it.

On-chip owners give the bus up only at the end of the bus cycle they are running, which the bus cycle logic marks with the `cyc_end` strobe. The off-chip master is different. It keeps the bus until the arbiter takes the acknowledge away, and it signals that it has released the bus by dropping its request. A refresh request flagged as urgent beats every other master. A plain refresh request ranks below the off-chip master.

Every change of owner passes through one clock in which nobody holds a grant. The grants are decoded from a single registered owner state, so two grants can never be active together. The off-chip request can be passed through a parameterised synchronizer before the arbiter uses it.

Top module: `bus_hold_arbiter`

## Requirements
- R1: While `rst` is high, all grants and `hldak` are low, whatever the requests. On the first clock after `rst` is released with no requests pending, `cpu_gnt` goes high.
- R2: At most one of `cpu_gnt`, `dma_gnt`, `ref_gnt` and `hldak` is high in any clock.
- R3: An on-chip owner keeps its grant until `cyc_end` is sampled high while another master wins arbitration. The grant then drops, and the next grant appears one clock later, so the clock between them has no grant.
- R4: In the clock with no owner, the winner is picked in this order: refresh with `ref_urgent` high, then DMA, then the off-chip request, then refresh with `ref_urgent` low, then the CPU. `ref_urgent` has meaning only while `ref_req` is high.
- R5: `hldak` rises no earlier than the second clock after a clock in which `hldrq` is sampled high and the current owner's `cyc_end` is sampled high.
- R6: While `hldak` is high, a DMA request or an urgent refresh request makes `hldak` drop on the next clock. A plain refresh request has no effect on `hldak`.
- R7: After `hldak` has been taken away, no grant is issued while `hldrq` stays high. The clock after `hldrq` is sampled low has no owner, and the winner is granted on the clock after that.
- R8: If `hldrq` drops while `hldak` is high, `hldak` falls on the next clock, and with no other request pending `cpu_gnt` rises one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dma_req | input | 1 | DMA engine asks for the bus |
| ref_req | input | 1 | Refresh engine asks for the bus |
| ref_urgent | input | 1 | Refresh request is urgent (top priority) |
| cyc_end | input | 1 | Current on-chip bus cycle finishes in this clock |
| hldrq | input | 1 | Off-chip master requests or holds the bus |
| cpu_gnt | output | 1 | CPU owns the bus |
| dma_gnt | output | 1 | DMA engine owns the bus |
| ref_gnt | output | 1 | Refresh engine owns the bus |
| hldak | output | 1 | Off-chip master may hold the bus |

## Verification
The bench builds the arbiter with `SYNC_STAGES` set to 0. In that build `hldrq` reaches the arbitration logic in the clock it is driven, so the exact edge counts in R5, R7 and R8 can be checked clock by clock against the pin. The bound checker watches the arbiter's own synchronized copy of the request, so its handshake properties stay valid when the default two-stage synchronizer delays that request.

// File: rtl/bha_pkg.sv
package bha_pkg;

    typedef enum logic [2:0] {
        OWN_NONE    = 3'd0,
        OWN_CPU     = 3'd1,
        OWN_DMA     = 3'd2,
        OWN_REF     = 3'd3,
        OWN_EXT     = 3'd4,
        OWN_EXT_RET = 3'd5
    } owner_e;

    typedef struct packed {
        logic dma;
        logic refr;
        logic urgent;
        logic hold;
    } req_t;

    typedef struct packed {
        logic cpu;
        logic dma;
        logic refr;
        logic ext;
    } gnt_t;

    // Fixed order: urgent refresh, DMA, off-chip hold, plain refresh, CPU.
    function automatic owner_e pick_winner(req_t r);
        if (r.refr && r.urgent) return OWN_REF;
        else if (r.dma)         return OWN_DMA;
        else if (r.hold)        return OWN_EXT;
        else if (r.refr)        return OWN_REF;
        else                    return OWN_CPU;
    endfunction

    // Requests that outrank the off-chip holder and so take the bus back.
    function automatic logic outranks_hold(req_t r);
        return r.dma || (r.refr && r.urgent);
    endfunction

    function automatic gnt_t decode_owner(owner_e o);
        gnt_t g;
        g      = '0;
        g.cpu  = (o == OWN_CPU);
        g.dma  = (o == OWN_DMA);
        g.refr = (o == OWN_REF);
        g.ext  = (o == OWN_EXT);
        return g;
    endfunction

endpackage

// File: rtl/bha_hold_sync.sv
module bha_hold_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= (pipe_q << 1) | STAGES'(d);
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/bha_prio_pick.sv
module bha_prio_pick
    import bha_pkg::*;
(
    input  req_t   req,
    output owner_e winner,
    output logic   reclaim
);
    always_comb begin
        winner  = pick_winner(req);
        reclaim = outranks_hold(req);
    end
endmodule

// File: rtl/bha_owner_fsm.sv
module bha_owner_fsm
    import bha_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  owner_e winner,
    input  logic   reclaim,
    input  logic   hold,
    input  logic   cyc_end,
    output owner_e owner
);
    owner_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OWN_NONE: st_d = winner;
            OWN_CPU, OWN_DMA, OWN_REF: begin
                if (cyc_end && (winner != st_q)) st_d = OWN_NONE;
            end
            OWN_EXT: begin
                if (!hold)        st_d = OWN_NONE;
                else if (reclaim) st_d = OWN_EXT_RET;
            end
            OWN_EXT_RET: begin
                if (!hold) st_d = OWN_NONE;
            end
            default: st_d = OWN_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= OWN_NONE;
        else     st_q <= st_d;
    end

    assign owner = st_q;
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
    import bha_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dma_req,
    input  logic ref_req,
    input  logic ref_urgent,
    input  logic cyc_end,
    input  logic hldrq,
    output logic cpu_gnt,
    output logic dma_gnt,
    output logic ref_gnt,
    output logic hldak
);
    logic   hold_req_s;
    req_t   req;
    owner_e winner;
    logic   reclaim;
    owner_e owner;
    gnt_t   gnt;

    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign hold_req_s = hldrq;
        end else begin : g_sync
            bha_hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk (clk),
                .rst (rst),
                .d   (hldrq),
                .q   (hold_req_s)
            );
        end
    endgenerate

    assign req = '{dma: dma_req, refr: ref_req, urgent: ref_urgent, hold: hold_req_s};

    bha_prio_pick u_pick (
        .req     (req),
        .winner  (winner),
        .reclaim (reclaim)
    );

    bha_owner_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .winner  (winner),
        .reclaim (reclaim),
        .hold    (hold_req_s),
        .cyc_end (cyc_end),
        .owner   (owner)
    );

    assign gnt     = decode_owner(owner);
    assign cpu_gnt = gnt.cpu;
    assign dma_gnt = gnt.dma;
    assign ref_gnt = gnt.refr;
    assign hldak   = gnt.ext;
endmodule

// File: rtl/bha_checker.sv
module bha_checker (
    input logic clk,
    input logic rst,
    input logic cpu_gnt,
    input logic dma_gnt,
    input logic ref_gnt,
    input logic hldak,
    input logic hold_req,
    input logic dma_req,
    input logic ref_req,
    input logic ref_urgent,
    input logic cyc_end
);
    logic any_gnt;
    logic int_gnt;
    logic ext_out_q;

    assign int_gnt = cpu_gnt || dma_gnt || ref_gnt;
    assign any_gnt = int_gnt || hldak;

    // Set once the acknowledge has been given, cleared once the request is seen low.
    always_ff @(posedge clk) begin
        if (rst)           ext_out_q <= 1'b0;
        else if (!hold_req) ext_out_q <= 1'b0;
        else if (hldak)    ext_out_q <= 1'b1;
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> !any_gnt);

    p_single_owner_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_gnt, dma_gnt, ref_gnt, hldak}));

    p_cpu_gap_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_gnt) |-> $past(!any_gnt));
    p_dma_gap_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_gnt) |-> $past(!any_gnt));
    p_ref_gap_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_gnt) |-> $past(!any_gnt));
    p_ext_gap_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(hldak) |-> $past(!any_gnt));

    p_dma_keep_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(dma_gnt) |-> $past(cyc_end));
    p_ref_keep_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(ref_gnt) |-> $past(cyc_end));

    p_ack_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(hldak) |-> $past(hold_req));

    p_reclaim_r6: assert property (@(posedge clk) disable iff (rst)
        (hldak && (dma_req || (ref_req && ref_urgent))) |=> !hldak);

    p_wait_release_r7: assert property (@(posedge clk) disable iff (rst)
        ext_out_q |-> !int_gnt);

    p_drop_follow_r8: assert property (@(posedge clk) disable iff (rst)
        (hldak && !hold_req) |=> !hldak);
endmodule

bind bus_hold_arbiter bha_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_gnt    (cpu_gnt),
    .dma_gnt    (dma_gnt),
    .ref_gnt    (ref_gnt),
    .hldak      (hldak),
    .hold_req   (hold_req_s),
    .dma_req    (dma_req),
    .ref_req    (ref_req),
    .ref_urgent (ref_urgent),
    .cyc_end    (cyc_end)
);

// File: tb/bus_hold_arbiter_tb_top.sv
module bus_hold_arbiter_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dma_req = 1'b0, ref_req = 1'b0, ref_urgent = 1'b0, cyc_end = 1'b0, hldrq = 1'b0;
    logic cpu_gnt, dma_gnt, ref_gnt, hldak;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bus_hold_arbiter #(.SYNC_STAGES(0)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .dma_req    (dma_req),
        .ref_req    (ref_req),
        .ref_urgent (ref_urgent),
        .cyc_end    (cyc_end),
        .hldrq      (hldrq),
        .cpu_gnt    (cpu_gnt),
        .dma_gnt    (dma_gnt),
        .ref_gnt    (ref_gnt),
        .hldak      (hldak)
    );

    // Entry: {dma, ref, urgent, hldrq, cyc_end, exp cpu, exp dma, exp ref, exp hldak}
    localparam int NV = 23;
    localparam logic [8:0] VEC [NV] = '{
        9'b10000_1000, // R3 DMA waits for cycle end
        9'b10001_0000, // R3 CPU releases, idle clock
        9'b10000_0100, // R4 DMA granted
        9'b11011_0100, // R4 DMA outranks hold and plain refresh
        9'b01011_0000, // R3 DMA releases at cycle end
        9'b01010_0001, // R4 hold outranks plain refresh
        9'b01010_0001, // R6 plain refresh does not reclaim
        9'b01110_0000, // R6 urgent refresh takes hldak away
        9'b01110_0000, // R7 wait while hldrq high
        9'b01100_0000, // R7 hldrq low, idle clock
        9'b01100_0010, // R7 urgent refresh granted
        9'b11111_0010, // R4 urgent refresh keeps bus over DMA
        9'b10011_0000, // R3 refresh releases
        9'b10010_0100, // R4 DMA over hold
        9'b00011_0000, // R3 DMA releases
        9'b00010_0001, // R4 hold granted
        9'b00000_0000, // R8 hldrq dropped, hldak falls
        9'b00000_1000, // R8 CPU back
        9'b01001_0000, // R4 plain refresh wins over CPU
        9'b01000_0010, // R4 refresh granted
        9'b01010_0010, // R3 no cycle end, refresh keeps bus
        9'b00001_0000, // R3 refresh releases
        9'b00000_1000  // R3 CPU default owner
    };
    localparam int VTAG [NV] = '{3,3,4,4,3,4,6,6,7,7,7,4,3,4,3,4,8,8,4,4,3,3,3};

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: grants {cpu,dma,ref,hldak} actual %b expected %b", tag, got, exp);
        end
    endtask

    task automatic step(input logic [4:0] in, input logic [3:0] exp, input string tag);
        logic [3:0] got;
        @(negedge clk);
        {dma_req, ref_req, ref_urgent, hldrq, cyc_end} = in;
        @(posedge clk);
        #1;
        got = {cpu_gnt, dma_gnt, ref_gnt, hldak};
        check(tag, got, exp);
        checks++;
        if ($countones(got) > 1) begin
            fails++;
            $display("FAIL R2: more than one grant, actual %b expected at most one bit", got);
        end
    endtask

    initial begin
        // R1: reset holds everything low even with every request up
        rst = 1'b1;
        {dma_req, ref_req, ref_urgent, hldrq, cyc_end} = 5'b11111;
        repeat (3) begin
            @(posedge clk);
            #1;
            check("R1", {cpu_gnt, dma_gnt, ref_gnt, hldak}, 4'b0000);
        end
        @(negedge clk);
        rst = 1'b0;
        {dma_req, ref_req, ref_urgent, hldrq, cyc_end} = 5'b00000;
        @(posedge clk);
        #1;
        check("R1", {cpu_gnt, dma_gnt, ref_gnt, hldak}, 4'b1000);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][8:4], VEC[i][3:0], $sformatf("R%0d vec%0d", VTAG[i], i));
        end

        // R5: hldrq alone does not move the CPU before a cycle end
        step(5'b00010, 4'b1000, "R5");
        step(5'b00010, 4'b1000, "R5");
        step(5'b00011, 4'b0000, "R5");
        step(5'b00010, 4'b0001, "R5");
        // R6/R7: DMA reclaims, then waits for the hold release
        step(5'b10010, 4'b0000, "R6");
        step(5'b10010, 4'b0000, "R7");
        step(5'b10000, 4'b0000, "R7");
        step(5'b10000, 4'b0100, "R7");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: all requirements, actual hung expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule